// File: doc/BRIEF.md
# AC-link Serial Frame Controller

This block is the controller end of a five-wire AC-link between a digital audio/modem controller and a codec. The codec supplies the bit clock (12.288 MHz, half of a 24.576 MHz crystal). The controller returns a frame marker on SYNC once every 256 bit periods, which gives a 48 kHz frame rate. The marker is held high for the first 16 bit periods of each frame. In the same bit periods, the block shifts one outgoing frame onto SDATA_OUT and collects one incoming frame from SDATA_IN. The link reset pin and the codec-ready handshake belong to a neighbouring block.

Every frame is 256 bits long. It starts with a 16-bit tag and continues with twelve 20-bit slots. Each field goes out most significant bit first. Bit 15 of the tag marks the frame as valid. Tag bit (15 − k) marks slot k (k = 1..12) as valid. The host passes a whole frame in parallel through a valid/ready handshake that opens once per frame. If the host has no frame ready at that moment, an empty frame is sent. A received frame is returned in parallel with a one-bit-period strobe.

Outgoing bits change on the rising bit-clock edge. Incoming bits are captured on the falling edge that follows, half a bit period later.

Top module: `aclink_ctrl`

## Requirements
- R1: `sync` is high in bit periods 0..15 of each frame and low in periods 16..255. The pattern repeats every 256 rising edges of `bit_clk`. A frame's period 0 is the period in which `sync` rises.
- R2: In bit period p of a frame, `sdata_out` carries frame bit p, updated on the rising edge. The frame is the tag (`tx_tag` bit 15 first), then slots 1..12, each 20 bits with the MSB first. Slot 1 occupies `tx_slots[239:220]` and slot 12 occupies `tx_slots[19:0]`.
- R3: When tag bit (15 − k) of the accepted frame is 0, all 20 bits of slot k are driven as 0 on `sdata_out`.
- R4: When `tx_valid` is low at the handshake, the next frame is sent as 256 zero bits, so every tag valid bit is clear.
- R5: `tx_ready` is high only during bit period 255 of each frame, and also in the period straight after reset. A frame is accepted on the rising edge that ends that period. Values on `tx_valid`, `tx_tag` and `tx_slots` at any other time have no effect on `sdata_out`.
- R6: `sdata_in` is sampled on the falling edge inside each bit period. The 256 bits of one frame come back with the first received bit at `rx_tag[15]` and the last at `rx_slots[0]`.
- R7: `rx_valid` is high for exactly bit period 0 of the next frame, once a full frame has been received. It stays low for the first frame after reset.
- R8: While `rst_n` is low: `sync`, `sdata_out` and `rx_valid` are 0, and `tx_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Serial bit clock from the codec |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync | output | 1 | Frame marker |
| sdata_out | output | 1 | Serial data to the codec |
| sdata_in | input | 1 | Serial data from the codec |
| tx_valid | input | 1 | Host offers an outgoing frame |
| tx_ready | output | 1 | Frame acceptance window |
| tx_tag | input | 16 | Outgoing tag field |
| tx_slots | input | 240 | Outgoing slots 1..12, slot 1 in the top bits |
| rx_valid | output | 1 | Received frame strobe |
| rx_tag | output | 16 | Received tag field |
| rx_slots | output | 240 | Received slots 1..12, slot 1 in the top bits |

## Verification
The in-RTL assertions check the frame-counter wrap, the rise and fall positions of `sync`, the zero level inside masked slots, the zero level of empty frames, and the placement of the receive strobe. They check these on every cycle. Only the bench scenarios can show whole-frame content: bit-exact serial order, the returned parallel frame after a falling-edge capture, and the fact that host inputs outside the acceptance window are ignored. The bench compares each bit period against frames that its own functions build.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
  localparam int TAG_W      = 16;
  localparam int SLOT_W     = 20;
  localparam int N_SLOTS    = 12;
  localparam int SLOTS_W    = N_SLOTS * SLOT_W;
  localparam int FRAME_W    = TAG_W + SLOTS_W;
  localparam int POS_W      = $clog2(FRAME_W);
  localparam int SLOT_IDX_W = $clog2(N_SLOTS + 1);
  localparam int SYNC_HI    = 16;

  // Field index of a bit position: 0 is the tag, 1..N_SLOTS are data slots.
  function automatic logic [SLOT_IDX_W-1:0] slot_of(input logic [POS_W-1:0] pos);
    if (int'(pos) < TAG_W) return '0;
    return SLOT_IDX_W'((int'(pos) - TAG_W) / SLOT_W + 1);
  endfunction

  // Whether a field may carry non-zero bits under a given tag.
  function automatic logic slot_enabled(input logic [TAG_W-1:0] tag,
                                        input logic [SLOT_IDX_W-1:0] idx);
    if (idx == '0) return 1'b1;
    return tag[TAG_W-1-int'(idx)];
  endfunction
endpackage

// File: rtl/aclink_frame_timer.sv
module aclink_frame_timer
  import aclink_pkg::*;
#(
  parameter int SYNC_HIGH_BITS = SYNC_HI
) (
  input  logic             bit_clk,
  input  logic             rst_n,
  output logic [POS_W-1:0] pos,
  output logic             frame_last,
  output logic             sync
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_W - 1);
  localparam logic [POS_W-1:0] SYNC_END = POS_W'(SYNC_HIGH_BITS);

  logic [POS_W-1:0] next_pos;

  assign frame_last = (pos == LAST_POS);
  assign next_pos   = frame_last ? '0 : pos + 1'b1;

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      pos  <= LAST_POS;
      sync <= 1'b0;
    end else begin
      pos  <= next_pos;
      sync <= (next_pos < SYNC_END);
    end
  end

  p_sync_rise_r1: assert property (@(posedge bit_clk) disable iff (!rst_n)
    $rose(sync) |-> (pos == '0));
  p_sync_fall_r1: assert property (@(posedge bit_clk) disable iff (!rst_n)
    $fell(sync) |-> (pos == SYNC_END));
  p_frame_wrap_r1: assert property (@(posedge bit_clk) disable iff (!rst_n)
    frame_last |=> (pos == '0) && sync);
endmodule

// File: rtl/aclink_tx_serializer.sv
module aclink_tx_serializer
  import aclink_pkg::*;
(
  input  logic               bit_clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [POS_W-1:0]   pos,
  input  logic               tx_valid,
  input  logic [TAG_W-1:0]   tx_tag,
  input  logic [SLOTS_W-1:0] tx_slots,
  output logic               sdata_out
);
  logic [SLOTS_W-1:0]    masked_slots;
  logic [FRAME_W-1:0]    load_frame;
  logic [FRAME_W-1:0]    shreg;
  logic [TAG_W-1:0]      cur_tag;
  logic [SLOT_IDX_W-1:0] slot_idx_now;
  logic                  slot_open;

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_mask
    assign masked_slots[SLOTS_W-1-s*SLOT_W -: SLOT_W] =
      tx_tag[TAG_W-2-s] ? tx_slots[SLOTS_W-1-s*SLOT_W -: SLOT_W] : '0;
  end

  assign load_frame = tx_valid ? {tx_tag, masked_slots} : '0;

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      cur_tag   <= '0;
      sdata_out <= 1'b0;
    end else if (load) begin
      sdata_out <= load_frame[FRAME_W-1];
      shreg     <= {load_frame[FRAME_W-2:0], 1'b0};
      cur_tag   <= load_frame[FRAME_W-1 -: TAG_W];
    end else begin
      sdata_out <= shreg[FRAME_W-1];
      shreg     <= {shreg[FRAME_W-2:0], 1'b0};
    end
  end

  // Field now on the wire and whether its tag bit allows data.
  assign slot_idx_now = slot_of(pos);
  assign slot_open    = slot_enabled(cur_tag, slot_idx_now);

  p_masked_zero_r3: assert property (@(posedge bit_clk) disable iff (!rst_n)
    !slot_open |-> !sdata_out);
  p_idle_frame_r4: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (load && !tx_valid) |=> !sdata_out && (cur_tag == '0));
endmodule

// File: rtl/aclink_rx_deserializer.sv
module aclink_rx_deserializer
  import aclink_pkg::*;
(
  input  logic               bit_clk,
  input  logic               rst_n,
  input  logic               sdata_in,
  input  logic [POS_W-1:0]   pos,
  input  logic               frame_last,
  output logic               rx_valid,
  output logic [TAG_W-1:0]   rx_tag,
  output logic [SLOTS_W-1:0] rx_slots
);
  logic [FRAME_W-1:0] capture;
  logic               primed;
  logic               frame_done;

  // Falling-edge capture, half a bit period after the codec launches.
  always_ff @(negedge bit_clk or negedge rst_n) begin
    if (!rst_n) capture <= '0;
    else        capture <= {capture[FRAME_W-2:0], sdata_in};
  end

  assign frame_done = frame_last && primed;

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      primed   <= 1'b0;
      rx_valid <= 1'b0;
      rx_tag   <= '0;
      rx_slots <= '0;
    end else begin
      primed   <= 1'b1;
      rx_valid <= frame_done;
      if (frame_done) {rx_tag, rx_slots} <= capture;
    end
  end

  p_rx_strobe_pos_r7: assert property (@(posedge bit_clk) disable iff (!rst_n)
    rx_valid |-> (pos == '0));
  p_rx_strobe_single_r7: assert property (@(posedge bit_clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
endmodule

// File: rtl/aclink_ctrl.sv
module aclink_ctrl
  import aclink_pkg::*;
#(
  parameter int SYNC_HIGH_BITS = SYNC_HI
) (
  input  logic                bit_clk,
  input  logic                rst_n,
  output logic                sync,
  output logic                sdata_out,
  input  logic                sdata_in,
  input  logic                tx_valid,
  output logic                tx_ready,
  input  logic [TAG_W-1:0]    tx_tag,
  input  logic [SLOTS_W-1:0]  tx_slots,
  output logic                rx_valid,
  output logic [TAG_W-1:0]    rx_tag,
  output logic [SLOTS_W-1:0]  rx_slots
);
  logic [POS_W-1:0] pos;
  logic             frame_last;

  aclink_frame_timer #(.SYNC_HIGH_BITS(SYNC_HIGH_BITS)) u_timer (
    .bit_clk    (bit_clk),
    .rst_n      (rst_n),
    .pos        (pos),
    .frame_last (frame_last),
    .sync       (sync)
  );

  assign tx_ready = frame_last;

  aclink_tx_serializer u_tx (
    .bit_clk   (bit_clk),
    .rst_n     (rst_n),
    .load      (frame_last),
    .pos       (pos),
    .tx_valid  (tx_valid),
    .tx_tag    (tx_tag),
    .tx_slots  (tx_slots),
    .sdata_out (sdata_out)
  );

  aclink_rx_deserializer u_rx (
    .bit_clk    (bit_clk),
    .rst_n      (rst_n),
    .sdata_in   (sdata_in),
    .pos        (pos),
    .frame_last (frame_last),
    .rx_valid   (rx_valid),
    .rx_tag     (rx_tag),
    .rx_slots   (rx_slots)
  );

  p_ready_before_sync_r5: assert property (@(posedge bit_clk) disable iff (!rst_n)
    tx_ready |=> $rose(sync));
  p_sync_after_ready_r5: assert property (@(posedge bit_clk) disable iff (!rst_n)
    $rose(sync) |-> $past(tx_ready));
endmodule

// File: tb/aclink_ctrl_tb.sv
`timescale 1ns/1ps
module aclink_ctrl_tb;
  localparam int CLK_PERIOD = 82;
  localparam int N_FRAMES   = 40;

  logic         bit_clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sdata_in = 1'b0;
  logic         tx_valid = 1'b0;
  logic [15:0]  tx_tag = '0;
  logic [239:0] tx_slots = '0;
  logic         sync, sdata_out, tx_ready, rx_valid;
  logic [15:0]  rx_tag;
  logic [239:0] rx_slots;

  aclink_ctrl u_dut (
    .bit_clk(bit_clk), .rst_n(rst_n), .sync(sync), .sdata_out(sdata_out),
    .sdata_in(sdata_in), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_tag(tx_tag), .tx_slots(tx_slots), .rx_valid(rx_valid),
    .rx_tag(rx_tag), .rx_slots(rx_slots)
  );

  always #(CLK_PERIOD/2) bit_clk = ~bit_clk;

  int total = 0;
  int bad = 0;
  int edge_cnt = 0;
  int cur_pos = 0;
  int frame_no = 0;
  int sync_err = 0, data_err = 0, ready_err = 0, rx_err = 0;
  bit done = 0;
  logic [255:0] exp_cur = '0;
  logic [255:0] codec_cur = '0;
  logic [255:0] codec_prev = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [255:0] rand256();
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[i*32 +: 32] = $urandom();
    return r;
  endfunction

  // Expected serial frame: zero when not offered, and zeroed slots whose tag bit is clear.
  function automatic logic [255:0] bench_expect(input logic v, input logic [15:0] tag,
                                                input logic [239:0] slots);
    logic [255:0] f;
    if (!v) return '0;
    f = {tag, slots};
    for (int k = 1; k <= 12; k++)
      if (!tag[15-k])
        for (int b = 0; b < 20; b++) f[239 - (k-1)*20 - b] = 1'b0;
    return f;
  endfunction

  task automatic drive_frame(input int n);
    tx_slots = rand256()[239:0];
    case (n)
      0: begin tx_valid = 1; tx_tag = 16'hFFF8; end
      1: begin tx_valid = 0; tx_tag = 16'hFFFF; end        // R4 idle frame
      2: begin tx_valid = 1; tx_tag = 16'h8000; tx_slots = '1; end  // R3 all masked
      3: begin tx_valid = 1; tx_tag = 16'hD550; end          // R3 alternating
      4: begin tx_valid = 1; tx_tag = 16'hFFFF; tx_slots = '1; end
      default: begin
        tx_valid = ($urandom_range(0, 3) != 0);
        tx_tag = 16'($urandom());
      end
    endcase
  endtask

  // Codec model: bench-side bit position and launch on the rising edge.
  always @(posedge bit_clk) begin
    if (rst_n) begin
      edge_cnt++;
      cur_pos = (edge_cnt - 1) % 256;
      if (cur_pos == 0) begin
        exp_cur = bench_expect(tx_valid, tx_tag, tx_slots);
        codec_prev = codec_cur;
        codec_cur = rand256();
        frame_no++;
      end
      #1 sdata_in = codec_cur[255 - cur_pos];
    end
  end

  // Checker and host on the falling edge.
  always @(negedge bit_clk) begin
    if (edge_cnt == 0) begin
      drive_frame(0);
    end else if (rst_n && !done) begin
      int p;
      p = cur_pos;
      if (sync !== (p < 16)) sync_err++;
      if (sdata_out !== exp_cur[255 - p]) data_err++;
      if (tx_ready !== (p == 255)) ready_err++;
      if (p == 0) begin
        if (frame_no >= 2) begin
          chk(rx_valid === 1'b1, "R7", "rx strobe at frame start", {255'd0, rx_valid}, 256'd1);
          chk({rx_tag, rx_slots} === codec_prev, "R6", "received frame",
              {rx_tag, rx_slots}, codec_prev);
        end else begin
          chk(rx_valid === 1'b0, "R7", "no strobe after first frame", {255'd0, rx_valid}, 256'd0);
        end
      end else if (rx_valid !== 1'b0) begin
        rx_err++;
      end
      if (p == 255) begin
        chk(sync_err == 0, "R1", "sync window errors", 256'(sync_err), 256'd0);
        chk(data_err == 0, "R2 R3 R4", $sformatf("serial bits frame %0d", frame_no - 1),
            256'(data_err), 256'd0);
        chk(ready_err == 0, "R5", "ready window errors", 256'(ready_err), 256'd0);
        chk(rx_err == 0, "R7", "stray rx strobes", 256'(rx_err), 256'd0);
        sync_err = 0; data_err = 0; ready_err = 0; rx_err = 0;
        if (frame_no >= N_FRAMES) done = 1;
        else drive_frame(frame_no);
      end else begin
        // R5: junk outside the acceptance window must not reach the wire.
        tx_valid = 1'($urandom());
        tx_tag = 16'($urandom());
        tx_slots = rand256()[239:0];
      end
    end
  end

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    void'($urandom(32'h5EED_0C0D));
    #(CLK_PERIOD * 3 + CLK_PERIOD / 4);
    chk(sync === 1'b0, "R8", "sync in reset", {255'd0, sync}, 256'd0);
    chk(sdata_out === 1'b0, "R8", "sdata_out in reset", {255'd0, sdata_out}, 256'd0);
    chk(rx_valid === 1'b0, "R8", "rx_valid in reset", {255'd0, rx_valid}, 256'd0);
    chk(tx_ready === 1'b1, "R8", "tx_ready in reset", {255'd0, tx_ready}, 256'd1);
    @(negedge bit_clk);
    rst_n = 1'b1;
    wait (done);
    #(CLK_PERIOD);
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end
endmodule